// File: doc/BRIEF.md
# Atomic-Alias Configuration Register Bank

A bank of small configuration registers, one per pad, sitting behind a simple address/data/strobe bus. Every register can be reached through four address windows. The window bits of the address, not the data, choose how a write changes the stored value: replace it, invert chosen bits, raise chosen bits or drop chosen bits. Software can therefore flip, set or clear one control bit in a single bus write, with no read-modify-write sequence and no race against other code that touches other bits of the same register.

Each register powers up with its isolation bit (bit 8) and its output-disable bit (bit 7) set, so a pad stays quiet until software explicitly clears them. The stored values leave the block as one flat port that the pad logic consumes. Reads return the current value one cycle after the read strobe and change nothing.

Top module: `regbank_atomic`

## Requirements
- R1: After reset every register holds RST_VAL masked by IMPL_MASK (default 0x196, which has bit 8 isolation and bit 7 output-disable set).
- R2: A write with address bits [13:12] = 0 (window offset 0x0000) replaces the register with the write data.
- R3: A write with address bits [13:12] = 1 (offset 0x1000) inverts exactly the register bits that are 1 in the write data.
- R4: A write with address bits [13:12] = 2 (offset 0x2000) sets exactly the register bits that are 1 in the write data.
- R5: A write with address bits [13:12] = 3 (offset 0x3000) clears exactly the register bits that are 1 in the write data.
- R6: Register n is at byte offset 4 + 4*n (address bits [11:2] = n+1, bits [1:0] ignored); writes to any other word change no register and reads of it return zero.
- R7: A read through any of the four windows returns the register's current value on bus_rdata one cycle after the read strobe and leaves every register unchanged.
- R8: A write takes effect on the clock edge that samples it: pad_cfg shows the new value right after that edge, with no wait cycle.
- R9: Bits outside IMPL_MASK (default 0x1FF) always hold and read as zero, whatever is written through any window.
- R10: A write changes only the addressed register; all others keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 14 | Byte address; [13:12] window, [11:2] word |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data / bit mask |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_ren |
| pad_cfg | output | NUM_REGS*32 | All register values, register n in bits [32n+31:32n] |

## Verification
A write is due on pad_cfg in the first cycle after the edge that samples the strobe, so the bench raises the strobe just after a falling edge and compares pad_cfg at the next falling edge, the earliest point the value can appear. Read data passes through one register, so the bench compares bus_rdata at the falling edge one cycle after the strobe, and checks pad_cfg at the same point to confirm the read left the bank alone. The sweep covers every register, every window and several data patterns, each followed by a full comparison of all registers against a bench-side model.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    // Update applied by a write, chosen by the top two address bits.
    typedef enum logic [1:0] {
        OP_REPLACE = 2'd0,
        OP_TOGGLE  = 2'd1,
        OP_RAISE   = 2'd2,
        OP_DROP    = 2'd3
    } wr_op_e;

endpackage

// File: rtl/regbank_decoder.sv
module regbank_decoder
    import regbank_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int NUM_REGS = 4
) (
    input  logic [ADDR_W-1:0]   addr,
    output wr_op_e              op,
    output logic [NUM_REGS-1:0] sel,
    output logic                hit
);
    localparam int WORD_W = ADDR_W - 4;

    logic [WORD_W-1:0] word;
    logic              unused_low;

    assign op         = wr_op_e'(addr[ADDR_W-1:ADDR_W-2]);
    assign word       = addr[ADDR_W-3:2];
    assign unused_low = ^addr[1:0];

    // Register n answers at word n+1; word 0 and words past the bank are holes.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        localparam logic [WORD_W-1:0] MY_WORD = WORD_W'(i + 1);
        assign sel[i] = (word == MY_WORD);
    end

    assign hit = |sel;

endmodule

// File: rtl/regbank_cell.sv
module regbank_cell
    import regbank_pkg::*;
#(
    parameter int               DATA_W    = 32,
    parameter logic [DATA_W-1:0] IMPL_MASK = 32'h0000_01FF,
    parameter logic [DATA_W-1:0] RST_VAL   = 32'h0000_0196
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  wr_op_e            op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value
);
    typedef struct packed {
        logic [DATA_W-1:0] val;
    } cell_state_t;

    cell_state_t st_d, st_q;
    logic [DATA_W-1:0] bits;

    always_comb begin
        st_d = st_q;
        bits = wdata & IMPL_MASK;
        if (wr_en) begin
            case (op)
                OP_REPLACE: st_d.val = bits;
                OP_TOGGLE:  st_d.val = st_q.val ^ bits;
                OP_RAISE:   st_d.val = st_q.val | bits;
                OP_DROP:    st_d.val = st_q.val & ~bits;
                default:    st_d.val = st_q.val;
            endcase
        end
        st_d.val = st_d.val & IMPL_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.val <= RST_VAL & IMPL_MASK;
        else        st_q     <= st_d;
    end

    assign value = st_q.val;

    // R10: no write strobe for this cell means the value holds.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(value));

    // R4: every masked bit named in the data is 1 afterwards.
    a_r4_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_RAISE) |=>
        ((value & $past(wdata & IMPL_MASK)) == $past(wdata & IMPL_MASK)));

    // R5: every bit named in the data is 0 afterwards.
    a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_DROP) |=> ((value & $past(wdata)) == '0));

    // R3: bits not named in the data keep their previous value.
    a_r3_toggle_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_TOGGLE) |=>
        ((value & ~$past(wdata)) == ($past(value) & ~$past(wdata))));

    // R9: unimplemented bits stay zero.
    a_r9_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((value & ~IMPL_MASK) == '0));

endmodule

// File: rtl/regbank_atomic.sv
module regbank_atomic
    import regbank_pkg::*;
#(
    parameter int               ADDR_W    = 14,
    parameter int               DATA_W    = 32,
    parameter int               NUM_REGS  = 4,
    parameter logic [DATA_W-1:0] IMPL_MASK = 32'h0000_01FF,
    parameter logic [DATA_W-1:0] RST_VAL   = 32'h0000_0196
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wen,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       bus_ren,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic [NUM_REGS*DATA_W-1:0] pad_cfg
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    wr_op_e                             op;
    logic [NUM_REGS-1:0]                sel;
    logic                               hit;
    logic [NUM_REGS-1:0][DATA_W-1:0]    regs;
    logic [DATA_W-1:0]                  rd_val;
    top_state_t                         st_d, st_q;

    regbank_decoder #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_dec (
        .addr (bus_addr),
        .op   (op),
        .sel  (sel),
        .hit  (hit)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        regbank_cell #(
            .DATA_W    (DATA_W),
            .IMPL_MASK (IMPL_MASK),
            .RST_VAL   (RST_VAL)
        ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bus_wen && sel[i]),
            .op    (op),
            .wdata (bus_wdata),
            .value (regs[i])
        );
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) rd_val = rd_val | regs[i];
        end
        st_d = st_q;
        if (bus_ren) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.rdata <= '0;
        else        st_q       <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign pad_cfg   = regs;

    // R7: a read with no write leaves the whole bank unchanged.
    a_r7_read_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ren && !bus_wen) |=> $stable(pad_cfg));

    // R6: a write that misses every register changes nothing.
    a_r6_hole_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && !hit) |=> $stable(pad_cfg));

    // R6: a read of a hole returns zero.
    a_r6_hole_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ren && !hit) |=> (bus_rdata == '0));

    // Decoder selects at most one register.
    a_r10_one_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

endmodule

// File: tb/regbank_atomic_tb.sv
module regbank_atomic_tb;
    localparam int          NR   = 4;
    localparam logic [31:0] MASK = 32'h0000_01FF;
    localparam logic [31:0] RSTV = 32'h0000_0196;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [13:0]       bus_addr = '0;
    logic              bus_wen = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_ren = 1'b0;
    logic [31:0]       bus_rdata;
    logic [NR*32-1:0]  pad_cfg;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] model [NR];

    always #10 clk = ~clk;

    regbank_atomic u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_ren   (bus_ren),
        .bus_rdata (bus_rdata),
        .pad_cfg   (pad_cfg)
    );

    function automatic logic [13:0] addr_of(int win, int word);
        return 14'((win << 12) | (word << 2));
    endfunction

    function automatic logic [31:0] apply(int win, logic [31:0] cur, logic [31:0] d);
        logic [31:0] m;
        m = d & MASK;
        case (win)
            0: return m;
            1: return cur ^ m;
            2: return cur | m;
            default: return cur & ~m;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_bank(string req);
        for (int i = 0; i < NR; i++) check(req, pad_cfg[i*32 +: 32], model[i]);
    endtask

    // Strobe driven after a falling edge, sampled at the next rising edge,
    // result observed at the following falling edge.
    task automatic bus_write(logic [13:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic bus_read(logic [13:0] a, output logic [31:0] d);
        bus_addr = a; bus_ren = 1'b1;
        @(negedge clk);
        bus_ren = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] pats [5];
        pats[0] = 32'hFFFF_FFFF;
        pats[1] = 32'h0000_0180;
        pats[2] = 32'hA5A5_A5A5;
        pats[3] = 32'h5A5A_5A5A;
        pats[4] = 32'h0000_0011;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset value on every register, through port and read path.
        for (int i = 0; i < NR; i++) model[i] = RSTV & MASK;
        check_bank("R1");
        for (int i = 0; i < NR; i++) begin
            bus_read(addr_of(i % 4, i + 1), rd);
            check("R1", rd, RSTV);
        end

        // R2..R5, R8, R9, R10: every register, every window, several patterns.
        for (int r = 0; r < NR; r++) begin
            for (int w = 0; w < 4; w++) begin
                for (int p = 0; p < 5; p++) begin
                    bus_write(addr_of(w, r + 1) | 14'((p & 1) ? 2'b11 : 2'b00), pats[p]);
                    model[r] = apply(w, model[r], pats[p]);
                    case (w)
                        0: check("R2", pad_cfg[r*32 +: 32], model[r]);
                        1: check("R3", pad_cfg[r*32 +: 32], model[r]);
                        2: check("R4", pad_cfg[r*32 +: 32], model[r]);
                        default: check("R5", pad_cfg[r*32 +: 32], model[r]);
                    endcase
                    check_bank("R8_R10");
                    check("R9", pad_cfg[r*32 +: 32] & ~MASK, 32'h0);
                    // R7: read through a rotating window, nothing changes.
                    bus_read(addr_of((w + p) % 4, r + 1), rd);
                    check("R7", rd, model[r]);
                    check_bank("R7");
                end
            end
        end

        // R6: holes at word 0 and past the bank, all windows.
        for (int w = 0; w < 4; w++) begin
            bus_write(addr_of(w, 0), 32'hFFFF_FFFF);
            check_bank("R6");
            bus_write(addr_of(w, NR + 1), 32'h0000_0000);
            check_bank("R6");
            bus_read(addr_of(w, 0), rd);
            check("R6", rd, 32'h0);
            bus_read(addr_of(w, NR + 1), rd);
            check("R6", rd, 32'h0);
        end

        // R5 then R4 on the pad enable bits only, other bits untouched.
        bus_write(addr_of(0, 2), 32'h0000_01FF);
        model[1] = 32'h0000_01FF;
        bus_write(addr_of(3, 2), 32'h0000_0180);
        model[1] = 32'h0000_007F;
        check("R5", pad_cfg[32 +: 32], model[1]);
        bus_write(addr_of(2, 2), 32'h0000_0100);
        model[1] = 32'h0000_017F;
        check("R4", pad_cfg[32 +: 32], model[1]);
        check_bank("R10");

        // R1: reset brings every register back.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NR; i++) model[i] = RSTV;
        check_bank("R1");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule